// File: doc/BRIEF.md
# I2C LED Output Latch Controller

This block is an I2C target that sets eight low-side LED switch bits. A fast system clock oversamples the bus. SCL and SDA first pass through a synchronizer and a width filter. The block drives SDA only through an active-high pull-down enable, so an external open-drain pad or a wired-AND model sets the line level.

A transaction starts with an address byte. Its upper nibble must be the fixed group code 1100, the next three bits must equal the strap pins, and the last bit is the read/write flag. A write then sends a command byte. The command selects one of three actions:

- 11H loads a holding register.
- 22H copies the holding register into the output register.
- 44H loads the holding register and copies it in the same step.

A read returns the holding register. The output register reaches the switch pins through a gate. The gate forces every switch off while the enable pin is high or the thermal-disable input is active.

Top module: `led_latch_i2c`

## Requirements
- R1: The address byte, MSB first, is acknowledged only when bits 7..4 equal 1100 and bits 3..1 equal `strap_addr`. Bit 0 is the read flag (0 = write). On any other address byte the block acknowledges nothing and changes nothing until the next start or stop.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop in the middle of a byte abandons that byte and leaves both registers unchanged.
- R3: Command 11H acknowledges the command and the following data byte. The data byte goes into the holding register, and the output register keeps its value.
- R4: Command 22H copies the holding register into the output register in the acknowledge slot of the command byte. A data byte sent after it gets no acknowledge and has no effect.
- R5: Command 44H acknowledges the data byte. In that acknowledge slot the data byte is written to both the holding register and the output register.
- R6: Any other command byte gets no acknowledge. A data byte after it also gets no acknowledge, and neither byte changes any register.
- R7: A read returns the holding register MSB first, one bit per SCL low phase. The read sequence is: write address, command 11H, repeated start, then the address with the read flag set to 1.
- R8: The block pulls SDA low only in its own acknowledge slots and for the 0 bits of a read byte. It never drives SDA high.
- R9: A synchronous reset clears the holding register and the output register, turns all drive bits off and releases SDA.
- R10: While `out_en_n` is low, `drive` equals the output register one clock later. While `out_en_n` is high, `drive` is all zero one clock later.
- R11: While `therm_off` is high, `drive` is all zero one clock later, whatever the other inputs are.
- R12: A pulse on SCL or SDA shorter than FILT_CYC system clocks is ignored. It does not act as a clock edge, a start or a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset (power-up clear) |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull SDA low |
| strap_addr | input | 3 | Device address straps |
| out_en_n | input | 1 | Active-low enable for the switch outputs |
| therm_off | input | 1 | 1 = force all switches off |
| drive | output | 8 | Switch controls, 1 = switch sinks current |

## Verification
A wrong protocol state shows up at the ports within the same byte. The block then answers a wrong acknowledge in the ninth SCL slot, or pulls SDA during a master-driven bit, so the master's next sample already sees the fault. A fault in a register update takes longer to show. A bad output register appears on `drive` one clock after the acknowledge slot, and only while the enable is low and thermal disable is off. A bad holding register stays hidden until a later copy command or a read-back exposes it. For that reason the random sequences interleave loads, copies and reads.

// File: rtl/ledl_pkg.sv
package ledl_pkg;
  localparam int BYTE_W = 8;
  localparam logic [3:0] GROUP_CODE = 4'b1100;
  localparam logic [BYTE_W-1:0] CMD_LOAD      = 8'h11;
  localparam logic [BYTE_W-1:0] CMD_COPY      = 8'h22;
  localparam logic [BYTE_W-1:0] CMD_LOAD_COPY = 8'h44;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_SUB,
    ST_SUB_ACK,
    ST_DATA,
    ST_DATA_ACK,
    ST_RD,
    ST_RD_ACK,
    ST_IGNORE
  } bus_state_e;
endpackage

// File: rtl/ledl_glitch_filter.sv
module ledl_glitch_filter #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 8,
  parameter bit RST_VAL     = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          cnt_q;
  logic                   filt_q;
  logic                   s;

  assign s    = sync_q[SYNC_STAGES-1];
  assign dout = filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= {SYNC_STAGES{RST_VAL}};
      cnt_q  <= '0;
      filt_q <= RST_VAL;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], din};
      if (s == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_q <= s;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  AST_FILT_MIN_WIDTH: assert property (@(posedge clk) disable iff (rst)
    !$stable(filt_q) |-> $past(cnt_q) == LAST); // R12
endmodule

// File: rtl/ledl_bus_fsm.sv
module ledl_bus_fsm
  import ledl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_f,
  input  logic              sda_f,
  input  logic [2:0]        strap,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] out_reg
);
  localparam logic [3:0] BYTE_DONE = 4'(BYTE_W);

  bus_state_e        state_q;
  logic              scl_d, sda_d;
  logic [3:0]        bit_cnt_q;
  logic [BYTE_W-1:0] rx_q, tx_q, hold_q, out_q, cmd_q;
  logic              rw_q, oe_q;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              byte_end, addr_hit, sub_known;

  assign scl_rise  = scl_f & ~scl_d;
  assign scl_fall  = ~scl_f & scl_d;
  assign start_ev  = scl_f & scl_d & sda_d & ~sda_f;
  assign stop_ev   = scl_f & scl_d & ~sda_d & sda_f;
  assign byte_end  = scl_fall && (bit_cnt_q == BYTE_DONE);
  assign addr_hit  = (rx_q[7:4] == GROUP_CODE) && (rx_q[3:1] == strap);
  assign sub_known = (rx_q == CMD_LOAD) || (rx_q == CMD_COPY) ||
                     (rx_q == CMD_LOAD_COPY);
  assign sda_oe    = oe_q;
  assign out_reg   = out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      bit_cnt_q <= '0;
      rx_q      <= '0;
      tx_q      <= '0;
      hold_q    <= '0;
      out_q     <= '0;
      cmd_q     <= '0;
      rw_q      <= 1'b0;
      oe_q      <= 1'b0;
    end else if (stop_ev) begin
      state_q <= ST_IDLE;
      oe_q    <= 1'b0;
    end else if (start_ev) begin
      state_q   <= ST_ADDR;
      bit_cnt_q <= '0;
      oe_q      <= 1'b0;
    end else begin
      case (state_q)
        ST_ADDR, ST_SUB, ST_DATA: begin
          if (scl_rise) begin
            rx_q      <= {rx_q[BYTE_W-2:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_end) begin
            bit_cnt_q <= '0;
            if (state_q == ST_ADDR) begin
              if (addr_hit) begin
                state_q <= ST_ADDR_ACK;
                rw_q    <= rx_q[0];
                oe_q    <= 1'b1;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else if (state_q == ST_SUB) begin
              if (sub_known) begin
                state_q <= ST_SUB_ACK;
                cmd_q   <= rx_q;
                oe_q    <= 1'b1;
                if (rx_q == CMD_COPY) out_q <= hold_q;
              end else begin
                state_q <= ST_IGNORE;
              end
            end else begin
              state_q <= ST_DATA_ACK;
              oe_q    <= 1'b1;
              hold_q  <= rx_q;
              if (cmd_q == CMD_LOAD_COPY) out_q <= rx_q;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt_q <= '0;
            if (rw_q) begin
              state_q <= ST_RD;
              tx_q    <= hold_q;
              oe_q    <= ~hold_q[BYTE_W-1];
            end else begin
              state_q <= ST_SUB;
              oe_q    <= 1'b0;
            end
          end
        end
        ST_SUB_ACK: begin
          if (scl_fall) begin
            oe_q      <= 1'b0;
            bit_cnt_q <= '0;
            state_q   <= (cmd_q == CMD_COPY) ? ST_IGNORE : ST_DATA;
          end
        end
        ST_DATA_ACK: begin
          if (scl_fall) begin
            oe_q    <= 1'b0;
            state_q <= ST_IGNORE;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            bit_cnt_q <= bit_cnt_q + 1'b1;
          end else if (byte_end) begin
            oe_q    <= 1'b0;
            state_q <= ST_RD_ACK;
          end else if (scl_fall) begin
            tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
            oe_q <= ~tx_q[BYTE_W-2];
          end
        end
        ST_RD_ACK: begin
          if (scl_fall) state_q <= ST_IGNORE;
        end
        default: oe_q <= 1'b0;
      endcase
    end
  end

  AST_OE_ONLY_IN_SLOTS: assert property (@(posedge clk) disable iff (rst)
    oe_q |-> (state_q inside {ST_ADDR_ACK, ST_SUB_ACK, ST_DATA_ACK, ST_RD})); // R8
  AST_OUT_CHANGES_AT_ACK: assert property (@(posedge clk) disable iff (rst)
    !$stable(out_q) |-> (state_q inside {ST_SUB_ACK, ST_DATA_ACK})); // R4
  AST_UNKNOWN_CMD_NO_ACK: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SUB && byte_end && !sub_known && !start_ev && !stop_ev)
      |=> (state_q == ST_IGNORE && !oe_q)); // R6
  AST_HOLD_STABLE_IN_READ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RD) |=> $stable(hold_q)); // R7
  AST_MISMATCH_SILENT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IGNORE) |-> !oe_q); // R1
endmodule

// File: rtl/ledl_drive_gate.sv
module ledl_drive_gate #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] out_reg,
  input  logic         out_en_n,
  input  logic         therm_off,
  output logic [W-1:0] drive
);
  logic [W-1:0] drive_q;
  assign drive = drive_q;

  always_ff @(posedge clk) begin
    if (rst)                        drive_q <= '0;
    else if (out_en_n || therm_off) drive_q <= '0;
    else                            drive_q <= out_reg;
  end

  AST_ENABLE_HIGH_OFF: assert property (@(posedge clk) disable iff (rst)
    out_en_n |=> (drive_q == '0)); // R10
  AST_THERMAL_OFF: assert property (@(posedge clk) disable iff (rst)
    therm_off |=> (drive_q == '0)); // R11
endmodule

// File: rtl/led_latch_i2c.sv
module led_latch_i2c
  import ledl_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_CYC    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [2:0]        strap_addr,
  input  logic              out_en_n,
  input  logic              therm_off,
  output logic [BYTE_W-1:0] drive
);
  localparam int N_LINES = 2;

  logic [N_LINES-1:0] raw_lines, clean_lines;
  logic [BYTE_W-1:0]  out_reg;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    ledl_glitch_filter #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_CYC   (FILT_CYC),
      .RST_VAL    (1'b1)
    ) u_filt (
      .clk (clk),
      .rst (rst),
      .din (raw_lines[g]),
      .dout(clean_lines[g])
    );
  end

  ledl_bus_fsm u_fsm (
    .clk    (clk),
    .rst    (rst),
    .scl_f  (clean_lines[0]),
    .sda_f  (clean_lines[1]),
    .strap  (strap_addr),
    .sda_oe (sda_oe),
    .out_reg(out_reg)
  );

  ledl_drive_gate #(.W(BYTE_W)) u_gate (
    .clk      (clk),
    .rst      (rst),
    .out_reg  (out_reg),
    .out_en_n (out_en_n),
    .therm_off(therm_off),
    .drive    (drive)
  );
endmodule

// File: tb/test_led_latch_i2c.sv
`timescale 1ns/1ps
module test_led_latch_i2c;
  localparam int Q = 20;
  localparam logic [2:0] STRAP = 3'b101;
  localparam int WDOG = 190000;

  logic clk = 1'b0, rst = 1'b1;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic out_en_n = 1'b0, therm_off = 1'b0;
  logic sda_oe;
  logic [7:0] drive;
  logic sda_w;
  assign sda_w = sda_m & ~sda_oe;

  int n_vec = 0, n_bad = 0;
  logic [7:0] hold_m = 8'h00, out_m = 8'h00;
  bit done = 1'b0;

  always #4 clk = ~clk;

  led_latch_i2c i_led_latch_i2c (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_w), .sda_oe(sda_oe),
    .strap_addr(STRAP), .out_en_n(out_en_n), .therm_off(therm_off), .drive(drive)
  );

  function automatic logic [7:0] exp_drive(logic [7:0] o, logic en_n, logic th);
    return (en_n || th) ? 8'h00 : o;
  endfunction

  function automatic logic [7:0] addr_byte(logic rw);
    return {4'b1100, STRAP, rw};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop;
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(logic b, bit glitch);
    sda_m = b;
    if (glitch) begin
      tick(4); scl_m = 1'b1; tick(3); scl_m = 1'b0; tick(Q - 7);
    end else tick(Q);
    scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    b = sda_w; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic put_byte(logic [7:0] v, int glitch_bit, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(v[i], glitch_bit == i);
    get_bit(b);
    ack = ~b;
  endtask

  task automatic read_back(string req);
    logic a0, a1, a2, b;
    logic [7:0] v;
    bus_start; put_byte(addr_byte(1'b0), -1, a0); put_byte(8'h11, -1, a1);
    bus_start; put_byte(addr_byte(1'b1), -1, a2);
    for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
    put_bit(1'b1, 1'b0);
    bus_stop;
    check({req, " read acks"}, {5'b0, a0, a1, a2}, 8'h07);
    check({req, " read data"}, v, hold_m);
  endtask

  // Writes one command; updates the model and checks acks.
  task automatic write_cmd(logic [7:0] ab, logic [7:0] sub, logic [7:0] data, int glitch_bit);
    logic a0, a1, a2;
    logic match;
    logic [2:0] exp;
    string req;
    match = (ab[7:4] == 4'b1100) && (ab[3:1] == STRAP);
    bus_start;
    put_byte(ab, -1, a0);
    put_byte(sub, -1, a1);
    put_byte(data, glitch_bit, a2);
    bus_stop;
    if (!match) begin exp = 3'b000; req = "R1"; end
    else if (sub == 8'h11) begin exp = 3'b111; req = "R3"; hold_m = data; end
    else if (sub == 8'h22) begin exp = 3'b110; req = "R4"; out_m = hold_m; end
    else if (sub == 8'h44) begin exp = 3'b111; req = "R5"; hold_m = data; out_m = data; end
    else begin exp = 3'b100; req = "R6"; end
    if (glitch_bit >= 0) req = "R12";
    check({req, " acks"}, {5'b0, a0, a1, a2}, {5'b0, exp});
    tick(3);
    check({req, " drive"}, drive, exp_drive(out_m, out_en_n, therm_off));
  endtask

  task automatic gate_check(logic en_n, logic th);
    out_en_n = en_n; therm_off = th; tick(2);
    check(th ? "R11 gate" : "R10 gate", drive, exp_drive(out_m, en_n, th));
    out_en_n = 1'b0; therm_off = 1'b0; tick(2);
    check("R10 follow", drive, out_m);
  endtask

  initial begin : watchdog
    int cyc = 0;
    while (!done && cyc < WDOG) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin : stim
    logic a0, a1, b;
    void'($urandom(32'h1EDC0DE5));
    out_en_n = 1'b0;
    tick(5); rst = 1'b0; tick(3);
    check("R9 reset drive", drive, 8'h00);
    check("R9 reset sda", {7'b0, sda_oe}, 8'h00);
    read_back("R9");

    // Directed corner cases
    write_cmd(addr_byte(1'b0), 8'h11, 8'hA5, -1);   // R3 load only
    write_cmd(addr_byte(1'b0), 8'h22, 8'h3C, -1);   // R4 copy, data ignored
    write_cmd(addr_byte(1'b0), 8'h44, 8'h96, -1);   // R5 load and copy
    write_cmd({4'b1100, STRAP ^ 3'b010, 1'b0}, 8'h44, 8'h0F, -1); // R1 mismatch
    write_cmd({4'b1101, STRAP, 1'b0}, 8'h44, 8'h0F, -1);          // R1 group
    write_cmd(addr_byte(1'b0), 8'h33, 8'hFF, -1);   // R6 unknown
    write_cmd(addr_byte(1'b0), 8'h44, 8'h5A, 3);    // R12 SCL glitch
    read_back("R7");

    // R2: stop in the middle of a data byte abandons it
    bus_start; put_byte(addr_byte(1'b0), -1, a0); put_byte(8'h44, -1, a1);
    for (int i = 0; i < 4; i++) put_bit(1'b0, 1'b0);
    bus_stop; tick(3);
    check("R2 abort drive", drive, out_m);
    read_back("R2");

    // R12: short SDA pulse while SCL high is neither stop nor start
    sda_m = 1'b0; tick(3); sda_m = 1'b1; tick(Q);
    write_cmd(addr_byte(1'b0), 8'h11, 8'hC3, -1);
    read_back("R12");

    gate_check(1'b1, 1'b0);
    gate_check(1'b0, 1'b1);

    // R8: idle bus, SDA must stay released
    tick(Q);
    check("R8 idle sda", {7'b0, sda_oe}, 8'h00);

    // Constrained random mix
    for (int n = 0; n < 16; n++) begin
      int op;
      logic [7:0] d, s;
      op = $urandom_range(0, 5);
      d = 8'($urandom_range(0, 255));
      case (op)
        0: write_cmd(addr_byte(1'b0), 8'h11, d, -1);
        1: write_cmd(addr_byte(1'b0), 8'h22, d, -1);
        2: write_cmd(addr_byte(1'b0), 8'h44, d, -1);
        3: read_back("R7");
        4: begin
          do s = 8'($urandom_range(0, 255));
          while (s == 8'h11 || s == 8'h22 || s == 8'h44);
          write_cmd(addr_byte(1'b0), s, d, -1);
        end
        default: write_cmd({4'b1100, STRAP ^ 3'($urandom_range(1, 7)), 1'b0},
                           8'h44, d, -1);
      endcase
      gate_check(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end
    read_back("R3");

    // R9: reset clears both registers
    rst = 1'b1; tick(3); rst = 1'b0; hold_m = 8'h00; out_m = 8'h00; tick(3);
    check("R9 post drive", drive, 8'h00);
    read_back("R9");
    get_bit(b);
    check("R8 released", {7'b0, b}, 8'h01);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule